// File: doc/BRIEF.md
# Grouped-Priority Vectored Interrupt Controller

This block gathers five interrupt sources and turns them into one interrupt request with a vector index for a small CPU core. Four sources are active-low external port lines, and each is captured on its falling edge. The fifth source is a one-cycle event pulse from a timer. Every captured event sets a pending bit, and the pending bit sets whether or not its source is enabled. Software can therefore poll pending events through the register port while interrupts stay off.

Software controls the winner among simultaneous requests. A three-bit code orders three groups. Group A holds one source. Groups B and C each hold two sources, and each of these two groups has a swap bit that orders its pair. When the CPU acknowledges a request, the block clears the winner's pending bit and drops the global enable, so no further request is raised until software enables it again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending register, the enable register and the priority settings are all zero, and `irq_o` is low.
- R2: Each external line passes through a two-flop synchronizer. A falling edge sets one pending bit three rising edges after the line changes: line 0 sets bit 3, line 1 sets bit 2, line 2 sets bit 0, and line 3 sets bit 1. A rising edge sets nothing.
- R3: A high `tmr_evt_i` sets pending bit 4 at the next rising edge.
- R4: Pending bits set and read back even when their enable bit or the global enable is 0.
- R5: Register select 1 holds the enables. Bits 4:0 enable sources 0 to 4, and bit 7 is the global enable. Bits 6:5 always read 0.
- R6: `irq_o` is high only when the global enable is 1, at least one pending source is enabled, and the order code is not 000 or 111.
- R7: The order code sits in priority bits 2:0. Group A is source 3, group B is sources 0 and 2, and group C is sources 1 and 4. The codes mean: 001 = C,A,B; 010 = A,B,C; 011 = A,C,B; 100 = B,C,A; 101 = C,B,A; 110 = B,A,C. The winner is taken from the first group in the order that has an enabled pending source, and `vec_o` gives the winner's source number.
- R8: Priority bit 3 orders group B: 0 puts source 2 ahead of source 0, and 1 puts source 0 ahead of source 2.
- R9: Priority bit 4 orders group C: 0 puts source 1 ahead of source 4, and 1 puts source 4 ahead of source 1.
- R10: When `ack_i` is high while `irq_o` is high, the next edge clears the winner's pending bit and the global enable. All other pending bits are kept.
- R11: A write to select 0 replaces pending bits 4:0. A source event in the same cycle still sets its bit. An acknowledge in the same cycle as an enable-register write leaves the global enable at 0.
- R12: The priority register (select 2) is write-only and reads as 0. Select 3 writes have no effect and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n_i | input | 4 | Active-low external request lines |
| tmr_evt_i | input | 1 | Timer event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 pending, 1 enable, 2 priority |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Read select |
| rd_data_o | output | 8 | Read data |
| ack_i | input | 1 | CPU acknowledge of the current request |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 3 | Index of the winning source |

## Verification
Three pairs of actions can fall on the same clock edge:
- A source event and a software write to the pending register.
- A source event and the clear made by an acknowledge.
- An acknowledge and a software write that re-enables the global enable.

Directed cases line up a synchronized falling edge with a pending-register write that clears it, and they pair an acknowledge with an enable write. In each case the bench reads the registers back and expects the event and the acknowledge to win. The random phase drives timer pulses, acknowledges and register writes with no constraint on their timing. A bench model that applies the same precedence judges every outcome.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ext_n_i,
  input  logic       tmr_evt_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic [1:0] rd_sel_i,
  output logic [7:0] rd_data_o,
  input  logic       ack_i,
  output logic       irq_o,
  output logic [2:0] vec_o
);
  logic [3:0] s1, s2, s3;
  logic [4:0] pend_q, en_q;
  logic       gie_q, bsw_q, csw_q;
  logic [2:0] code_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '1; s2 <= '1; s3 <= '1;
    end else begin
      s1 <= ext_n_i; s2 <= s1; s3 <= s2;
    end

  wire [3:0] fall   = s3 & ~s2;
  wire [4:0] set_ev = {tmr_evt_i, fall[0], fall[1], fall[3], fall[2]};
  wire [4:0] live   = pend_q & en_q;

  logic [2:0] gpend;
  logic [2:0] gwin [3];
  logic [1:0] g1, g2, g3;
  logic       code_ok, hit;
  logic [2:0] win;

  always_comb begin
    gpend[0] = live[3];
    gpend[1] = live[0] | live[2];
    gpend[2] = live[1] | live[4];
    gwin[0]  = 3'd3;
    if (bsw_q) gwin[1] = live[0] ? 3'd0 : 3'd2;
    else       gwin[1] = live[2] ? 3'd2 : 3'd0;
    if (csw_q) gwin[2] = live[4] ? 3'd4 : 3'd1;
    else       gwin[2] = live[1] ? 3'd1 : 3'd4;
    code_ok = 1'b1;
    case (code_q)
      3'd1:    begin g1 = 2'd2; g2 = 2'd0; g3 = 2'd1; end
      3'd2:    begin g1 = 2'd0; g2 = 2'd1; g3 = 2'd2; end
      3'd3:    begin g1 = 2'd0; g2 = 2'd2; g3 = 2'd1; end
      3'd4:    begin g1 = 2'd1; g2 = 2'd2; g3 = 2'd0; end
      3'd5:    begin g1 = 2'd2; g2 = 2'd1; g3 = 2'd0; end
      3'd6:    begin g1 = 2'd1; g2 = 2'd0; g3 = 2'd2; end
      default: begin g1 = 2'd0; g2 = 2'd1; g3 = 2'd2; code_ok = 1'b0; end
    endcase
    if (gpend[g1])      win = gwin[g1];
    else if (gpend[g2]) win = gwin[g2];
    else                win = gwin[g3];
    hit = code_ok & (|live);
  end

  assign irq_o = gie_q & hit;
  assign vec_o = win;

  wire       take  = ack_i & irq_o;
  wire [4:0] clr   = take ? (5'd1 << win) : 5'd0;
  wire       wr_pd = wr_en_i && (wr_sel_i == 2'd0);
  wire       wr_en = wr_en_i && (wr_sel_i == 2'd1);
  wire       wr_pr = wr_en_i && (wr_sel_i == 2'd2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q <= '0; en_q <= '0; gie_q <= 1'b0;
      code_q <= '0; bsw_q <= 1'b0; csw_q <= 1'b0;
    end else begin
      pend_q <= ((wr_pd ? wr_data_i[4:0] : pend_q) & ~clr) | set_ev;
      if (wr_en) en_q <= wr_data_i[4:0];
      if (take)       gie_q <= 1'b0;
      else if (wr_en) gie_q <= wr_data_i[7];
      if (wr_pr) begin
        code_q <= wr_data_i[2:0];
        bsw_q  <= wr_data_i[3];
        csw_q  <= wr_data_i[4];
      end
    end

  always_comb
    case (rd_sel_i)
      2'd0:    rd_data_o = {3'b000, pend_q};
      2'd1:    rd_data_o = {gie_q, 2'b00, en_q};
      default: rd_data_o = 8'h00;
    endcase

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_ev) |=> ((pend_q & $past(set_ev)) == $past(set_ev))); // R4
  AST_GRANT_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gie_q); // R6
  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == 3'd0 || code_q == 3'd7) |-> !irq_o); // R6
  AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_q[vec_o] && en_q[vec_o])); // R7
  AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> (!gie_q && !irq_o)); // R10
  AST_ACK_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !set_ev[vec_o]) |=> !pend_q[$past(vec_o)]); // R10
endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  logic clk = 0, rst_n = 0;
  logic [3:0] ext_n = 4'hF;
  logic tmr = 0, wr_en = 0, ack = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic irq;
  logic [2:0] vec;
  int nchk = 0, nerr = 0;
  bit done = 0;

  irq_prio_ctrl dut (.clk(clk), .rst_n(rst_n), .ext_n_i(ext_n), .tmr_evt_i(tmr),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .ack_i(ack), .irq_o(irq), .vec_o(vec));

  always #4 clk = ~clk;

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic int exp_win(input logic [4:0] live, input logic [2:0] code,
                                 input logic bsw, input logic csw);
    int ord[5];
    int grp[3];
    int n = 0;
    case (code)
      3'd1: grp = '{2, 0, 1};
      3'd2: grp = '{0, 1, 2};
      3'd3: grp = '{0, 2, 1};
      3'd4: grp = '{1, 2, 0};
      3'd5: grp = '{2, 1, 0};
      3'd6: grp = '{1, 0, 2};
      default: return -1;
    endcase
    for (int k = 0; k < 3; k++) begin
      if (grp[k] == 0) begin ord[n] = 3; n++; end
      else if (grp[k] == 1) begin ord[n] = bsw ? 0 : 2; ord[n+1] = bsw ? 2 : 0; n += 2; end
      else begin ord[n] = csw ? 4 : 1; ord[n+1] = csw ? 1 : 4; n += 2; end
    end
    for (int k = 0; k < 5; k++) if (live[ord[k]]) return ord[k];
    return -1;
  endfunction

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk); rd_sel = s; #1 v = rd_data;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int map[4] = '{3, 2, 0, 1};
    logic [4:0] mp, me;
    logic mg, mb, mc;
    logic [2:0] mcode;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, v); chk("R1 pend", v, 0);
    rd(1, v); chk("R1 enable", v, 0);
    rd(2, v); chk("R12 prio read", v, 0);
    chk("R1 irq", irq, 0);

    wr(1, 8'hFF); rd(1, v); chk("R5 reserved bits", v, 8'h9F);
    wr(1, 8'h00);

    for (int j = 0; j < 4; j++) begin
      @(negedge clk); ext_n[j] = 0;
      repeat (4) @(negedge clk);
      rd(0, v); chk("R2 R4 edge map", v, 1 << map[j]);
      wr(0, 0);
      @(negedge clk); ext_n[j] = 1;
      repeat (4) @(negedge clk);
      rd(0, v); chk("R2 rising ignored", v, 0);
    end

    @(negedge clk); tmr = 1; @(negedge clk); tmr = 0;
    rd(0, v); chk("R3 timer", v, 8'h10);
    wr(0, 0);

    @(negedge clk); ext_n[0] = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = 0;
    @(negedge clk); wr_en = 0;
    rd(0, v); chk("R11 event beats write", v, 8'h08);
    ext_n[0] = 1; repeat (4) @(negedge clk);
    wr(0, 0);

    wr(1, 8'h9F);
    for (int p = 0; p < 4; p++) begin
      logic [4:0] pat;
      pat = (p == 0) ? 5'h1F : (p == 1) ? 5'h05 : (p == 2) ? 5'h12 : 5'h16;
      wr(0, {3'b0, pat});
      for (int c = 0; c < 32; c++) begin
        int e;
        wr(2, c[7:0]);
        e = exp_win(pat, c[2:0], c[3], c[4]);
        @(negedge clk);
        chk("R6 irq", irq, e >= 0);
        if (e >= 0) chk("R7 R8 R9 vector", vec, e);
      end
    end

    wr(2, 8'h02); wr(0, 8'h1F);
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
    rd(0, v); chk("R10 winner cleared", v, 8'h17);
    rd(1, v); chk("R10 gie cleared", v, 8'h1F);
    chk("R10 irq low", irq, 0);

    wr(1, 8'h9F);
    @(negedge clk); ack = 1; wr_en = 1; wr_sel = 1; wr_data = 8'h9F;
    @(negedge clk); ack = 0; wr_en = 0;
    rd(1, v); chk("R11 ack beats enable write", v, 8'h1F);

    wr(3, 8'hFF); rd(3, v); chk("R12 sel3", v, 0);
    rd(0, v); chk("R12 sel3 no effect", v, 8'h13);

    wr(0, 0); wr(1, 0); wr(2, 0);
    mp = 0; me = 0; mg = 0; mb = 0; mc = 0; mcode = 0;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 3000; i++) begin
      int e;
      logic [4:0] np;
      logic take;
      @(negedge clk);
      e = exp_win(mp & me, mcode, mb, mc);
      chk("R6 random irq", irq, mg && e >= 0);
      if (mg && e >= 0) chk("R7 random vector", vec, e);
      rd_sel = 0; #1 chk("R4 random pend", rd_data, {3'b0, mp});
      rd_sel = 1; #1 chk("R5 random enable", rd_data, {mg, 2'b0, me});
      wr_en = ($urandom % 3) == 0;
      wr_sel = 2'($urandom % 4);
      wr_data = 8'($urandom);
      if (wr_sel == 2 && ($urandom % 4) != 0) wr_data[2:0] = 3'(1 + $urandom % 6);
      ack = ($urandom % 3) == 0;
      tmr = ($urandom % 5) == 0;
      take = ack && mg && e >= 0;
      np = (wr_en && wr_sel == 0) ? wr_data[4:0] : mp;
      if (take) np[e] = 0;
      if (tmr) np[4] = 1;
      @(posedge clk);
      mp = np;
      if (wr_en && wr_sel == 1) begin me = wr_data[4:0]; mg = wr_data[7]; end
      if (take) mg = 0;
      if (wr_en && wr_sel == 2) begin mcode = wr_data[2:0]; mb = wr_data[3]; mc = wr_data[4]; end
    end
    @(negedge clk); wr_en = 0; ack = 0; tmr = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule